// File: doc/BRIEF.md
# DMA Channel Mask, Status and Holding Register Block

This block serves the processor side of a four-channel DMA controller. It decodes a 4-bit port address and active-low read and write strobes, and it holds three kinds of state. The first is the per-channel request mask, which gates each channel's request before the priority arbiter. The second is a status byte that reports terminal-count events and live requests. The third is an 8-bit holding register for the byte moved by a memory-to-memory transfer.

The transfer engine supplies, for each channel, the raw request, a one-cycle terminal-count pulse, a one-cycle external end-of-process pulse and the autoinitialize flag. The block returns the effective mask bits. The engine writes the holding register through a load strobe with data and reads it back through a dedicated output. Every processor access is sampled against the block clock. A write is committed once, on the first clock edge that sees its strobe low. A status read clears the event bits when its strobe is seen going high again.

Top module: `dma_mask_status`

## Requirements
- R1: Port decode applies only when address bit 3 is 1. Bits 2..0 select the function: 000 reads status, 010 writes one mask bit, 101 reads the holding register, 101 written is master clear, 110 written clears all mask bits, and 111 reads or writes all mask bits. Reads of any other address, and any read with address bit 3 at 0, return 0x00. Writes to other addresses leave the mask unchanged. `cpuDout` is 0x00 whenever `cpuRdN` is high.
- R2: A single-mask write takes the channel number from data bits 1..0 and the new mask value from data bit 2 (1 masks, 0 unmasks). Data bits 7..3 are ignored and no other channel changes.
- R3: An all-mask write loads data bits 3..0 into the mask bits of channels 0..3, ignoring bits 7..4. A write to the clear-mask address sets every mask bit to 0.
- R4: A read of all mask bits returns the channel 0..3 mask bits in data bits 3..0 and ones in bits 7..4.
- R5: Reset and master clear set all mask bits to 1 and clear the status byte and the holding register.
- R6: A terminal-count or external end-of-process pulse on a channel whose autoinitialize flag is 0 sets that channel's mask bit on the same clock edge. With the flag at 1 the mask bit is unchanged.
- R7: Status bits 3..0 are set by a terminal-count or end-of-process pulse of channels 0..3. A status read returns the value held before clearing, and these bits clear on the first clock edge that sees the read strobe high after the read.
- R8: A terminal-count pulse on the same edge as the status clear leaves its own bit set.
- R9: Status bits 7..4 show the request inputs of channels 0..3 as sampled on the previous clock edge, whatever the mask state.
- R10: A high `tempLoad` stores `tempDin` into the holding register on the clock edge. Master clear on the same edge wins and leaves 0x00.
- R11: On a channel that a processor write changes, the written value beats an automatic end-of-process mask set on the same edge. Channels that the write does not change still take the automatic set.
- R12: A write acts once per strobe, on the first clock edge that sees `cpuWrN` low. Holding the strobe low for further cycles repeats nothing, and `maskOut` shows the result right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 4 | Processor port address |
| cpuRdN | input | 1 | Read strobe, active low |
| cpuWrN | input | 1 | Write strobe, active low |
| cpuDin | input | 8 | Processor write data |
| cpuDout | output | 8 | Processor read data, 0x00 when not reading |
| chanReq | input | 4 | Raw request per channel |
| chanTc | input | 4 | Terminal-count pulse per channel |
| chanEop | input | 4 | External end-of-process pulse per channel |
| chanAutoInit | input | 4 | Autoinitialize flag per channel |
| tempLoad | input | 1 | Holding-register load strobe |
| tempDin | input | 8 | Holding-register load data |
| maskOut | output | 4 | Effective mask bit per channel |
| tempValue | output | 8 | Holding-register contents |

## Verification
Mask writes, master clear and holding-register loads become visible one clock edge after the first low cycle of their strobe. Terminal-count and end-of-process pulses take effect on the edge that samples them. Request status trails the request inputs by one edge. The status clear lands on the edge after the read strobe returns high. The bench changes inputs on falling edges and samples outputs either on the next falling edge or 5 ns into a read cycle, before the next rising edge. As a result, every value read is the state left by the previous rising edge. Tests where events coincide drive a pulse into exactly the rising edge that also commits a write or a status clear, so the priority rules are exercised at that edge.

// File: rtl/dmams_pkg.sv
package dmams_pkg;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_TEMP,
    RD_MASK
  } rdSel_t;

  typedef struct packed {
    logic mclr;
    logic wrSingle;
    logic wrAll;
    logic clrAll;
    logic clrTc;
  } ctlStrb_t;

  localparam logic [2:0] PORT_STATUS  = 3'd0;
  localparam logic [2:0] PORT_SINGLE  = 3'd2;
  localparam logic [2:0] PORT_TEMP    = 3'd5;
  localparam logic [2:0] PORT_CLRMASK = 3'd6;
  localparam logic [2:0] PORT_ALLMASK = 3'd7;

endpackage

// File: rtl/dmams_ctl.sv
module dmams_ctl
  import dmams_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cpuAddr,
  input  logic       cpuRdN,
  input  logic       cpuWrN,
  output ctlStrb_t   strb,
  output rdSel_t     rdSel
);

  logic wrNPrev;
  logic statRdActive;
  logic wrStart;
  logic portHit;

  assign portHit = cpuAddr[3];
  assign wrStart = wrNPrev && !cpuWrN;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrNPrev      <= 1'b1;
      statRdActive <= 1'b0;
    end else begin
      wrNPrev      <= cpuWrN;
      statRdActive <= !cpuRdN && portHit && (cpuAddr[2:0] == PORT_STATUS);
    end
  end

  always_comb begin
    strb          = '0;
    strb.mclr     = wrStart && portHit && (cpuAddr[2:0] == PORT_TEMP);
    strb.wrSingle = wrStart && portHit && (cpuAddr[2:0] == PORT_SINGLE);
    strb.wrAll    = wrStart && portHit && (cpuAddr[2:0] == PORT_ALLMASK);
    strb.clrAll   = wrStart && portHit && (cpuAddr[2:0] == PORT_CLRMASK);
    strb.clrTc    = statRdActive && cpuRdN;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (!cpuRdN && portHit) begin
      case (cpuAddr[2:0])
        PORT_STATUS:  rdSel = RD_STATUS;
        PORT_TEMP:    rdSel = RD_TEMP;
        PORT_ALLMASK: rdSel = RD_MASK;
        default:      rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dmams_dp.sv
module dmams_dp
  import dmams_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  ctlStrb_t       strb,
  input  rdSel_t         rdSel,
  input  logic [DW-1:0]  wrData,
  input  logic [NCH-1:0] chanReq,
  input  logic [NCH-1:0] chanTc,
  input  logic [NCH-1:0] chanEop,
  input  logic [NCH-1:0] chanAutoInit,
  input  logic           tempLoad,
  input  logic [DW-1:0]  tempDin,
  output logic [NCH-1:0] maskOut,
  output logic [DW-1:0]  tempValue,
  output logic [DW-1:0]  rdData
);

  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int STW  = 2 * NCH;

  logic [NCH-1:0] maskReg, maskNxt;
  logic [NCH-1:0] tcReg, tcNxt;
  logic [NCH-1:0] reqReg;
  logic [DW-1:0]  tempReg;
  logic [NCH-1:0] endEvt;
  logic [SELW-1:0] selCh;
  logic            selVal;
  logic            unusedWrData;

  assign endEvt       = chanTc | chanEop;
  assign selCh        = wrData[SELW-1:0];
  assign selVal       = wrData[SELW];
  assign unusedWrData = ^wrData;

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    always_comb begin
      maskNxt[ch] = maskReg[ch] | (endEvt[ch] & ~chanAutoInit[ch]);
      if (strb.wrAll)                                   maskNxt[ch] = wrData[ch];
      if (strb.clrAll)                                  maskNxt[ch] = 1'b0;
      if (strb.wrSingle && (selCh == SELW'(ch)))        maskNxt[ch] = selVal;
      if (strb.mclr)                                    maskNxt[ch] = 1'b1;
    end

    always_comb begin
      tcNxt[ch] = (tcReg[ch] & ~strb.clrTc) | endEvt[ch];
      if (strb.mclr) tcNxt[ch] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= '1;
      tcReg   <= '0;
      reqReg  <= '0;
      tempReg <= '0;
    end else begin
      maskReg <= maskNxt;
      tcReg   <= tcNxt;
      reqReg  <= strb.mclr ? '0 : chanReq;
      if (strb.mclr)      tempReg <= '0;
      else if (tempLoad)  tempReg <= tempDin;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_STATUS: rdData[STW-1:0] = {reqReg, tcReg};
      RD_TEMP:   rdData = tempReg;
      RD_MASK: begin
        rdData = '1;
        rdData[NCH-1:0] = maskReg;
      end
      default:   rdData = '0;
    endcase
  end

  assign maskOut   = maskReg;
  assign tempValue = tempReg;

endmodule

// File: rtl/dma_mask_status.sv
module dma_mask_status
  import dmams_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     cpuAddr,
  input  logic           cpuRdN,
  input  logic           cpuWrN,
  input  logic [DW-1:0]  cpuDin,
  output logic [DW-1:0]  cpuDout,
  input  logic [NCH-1:0] chanReq,
  input  logic [NCH-1:0] chanTc,
  input  logic [NCH-1:0] chanEop,
  input  logic [NCH-1:0] chanAutoInit,
  input  logic           tempLoad,
  input  logic [DW-1:0]  tempDin,
  output logic [NCH-1:0] maskOut,
  output logic [DW-1:0]  tempValue
);

  ctlStrb_t strb;
  rdSel_t   rdSel;

  dmams_ctl uCtl (
    .clk     (clk),
    .rst     (rst),
    .cpuAddr (cpuAddr),
    .cpuRdN  (cpuRdN),
    .cpuWrN  (cpuWrN),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  dmams_dp #(.NCH(NCH), .DW(DW)) uDp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .rdSel        (rdSel),
    .wrData       (cpuDin),
    .chanReq      (chanReq),
    .chanTc       (chanTc),
    .chanEop      (chanEop),
    .chanAutoInit (chanAutoInit),
    .tempLoad     (tempLoad),
    .tempDin      (tempDin),
    .maskOut      (maskOut),
    .tempValue    (tempValue),
    .rdData       (cpuDout)
  );

endmodule

// File: rtl/dmams_chk.sv
module dmams_chk
  import dmams_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     cpuAddr,
  input logic           cpuRdN,
  input logic [DW-1:0]  cpuDout,
  input logic [NCH-1:0] chanTc,
  input logic [NCH-1:0] chanEop,
  input logic [NCH-1:0] chanAutoInit,
  input logic [NCH-1:0] maskOut,
  input ctlStrb_t       strb
);

  logic anyWrite;
  logic [NCH-1:0] autoEvt;
  assign anyWrite = strb.mclr | strb.wrSingle | strb.wrAll | strb.clrAll;
  assign autoEvt  = (chanTc | chanEop) & ~chanAutoInit;

  a_r1_dout_idle: assert property (@(posedge clk) disable iff (rst)
    cpuRdN |-> (cpuDout == '0));

  a_r4_mask_read_ones: assert property (@(posedge clk) disable iff (rst)
    (!cpuRdN && cpuAddr == 4'hF) |-> (cpuDout[DW-1:NCH] == '1));

  a_r5_mclr_sets_mask: assert property (@(posedge clk) disable iff (rst)
    strb.mclr |=> (maskOut == '1));

  a_r3_clear_all: assert property (@(posedge clk) disable iff (rst)
    strb.clrAll |=> (maskOut == '0));

  a_r6_auto_mask: assert property (@(posedge clk) disable iff (rst)
    (!anyWrite && autoEvt != '0) |=> ((maskOut & $past(autoEvt)) == $past(autoEvt)));

  a_r12_strobes_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.mclr, strb.wrSingle, strb.wrAll, strb.clrAll}));

endmodule

bind dma_mask_status dmams_chk #(.NCH(NCH), .DW(DW)) uChk (
  .clk          (clk),
  .rst          (rst),
  .cpuAddr      (cpuAddr),
  .cpuRdN       (cpuRdN),
  .cpuDout      (cpuDout),
  .chanTc       (chanTc),
  .chanEop      (chanEop),
  .chanAutoInit (chanAutoInit),
  .maskOut      (maskOut),
  .strb         (strb)
);

// File: tb/tb_dma_mask_status.sv
`timescale 1ns/1ps
module tb_dma_mask_status;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cpuAddr;
  logic       cpuRdN, cpuWrN;
  logic [7:0] cpuDin, cpuDout;
  logic [3:0] chanReq, chanTc, chanEop, chanAutoInit;
  logic       tempLoad;
  logic [7:0] tempDin, tempValue;
  logic [3:0] maskOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_mask_status dut (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuRdN(cpuRdN), .cpuWrN(cpuWrN),
    .cpuDin(cpuDin), .cpuDout(cpuDout), .chanReq(chanReq), .chanTc(chanTc),
    .chanEop(chanEop), .chanAutoInit(chanAutoInit), .tempLoad(tempLoad),
    .tempDin(tempDin), .maskOut(maskOut), .tempValue(tempValue)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [3:0] a, input logic [7:0] d);
    cpuAddr = a; cpuDin = d; cpuWrN = 1'b0;
    @(negedge clk);
    cpuWrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cpuRead(input logic [3:0] a, output logic [7:0] d);
    cpuAddr = a; cpuRdN = 1'b0;
    #5;
    d = cpuDout;
    @(negedge clk);
    cpuRdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseEnd(input logic [3:0] tc, input logic [3:0] eop);
    chanTc = tc; chanEop = eop;
    @(negedge clk);
    chanTc = '0; chanEop = '0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] expv;
    rst = 1; cpuAddr = 0; cpuRdN = 1; cpuWrN = 1; cpuDin = 0;
    chanReq = 0; chanTc = 0; chanEop = 0; chanAutoInit = 0;
    tempLoad = 0; tempDin = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // Reset state (R5, R1, R4)
    check("R5 reset mask", {4'h0, maskOut}, 8'h0F);
    check("R1 idle dout", cpuDout, 8'h00);
    cpuRead(4'h8, rd); check("R5 reset status", rd, 8'h00);
    cpuRead(4'hD, rd); check("R5 reset temp", rd, 8'h00);
    cpuRead(4'hF, rd); check("R4 reset mask read", rd, 8'hFF);

    // Address sweep of reads (R1)
    tempDin = 8'h5A; tempLoad = 1; @(negedge clk); tempLoad = 0;
    cpuWrite(4'hF, 8'h05);
    chanReq = 4'b1010; @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      cpuRead(a[3:0], rd);
      expv = (a == 8) ? 8'hA0 : (a == 13) ? 8'h5A : (a == 15) ? 8'hF5 : 8'h00;
      check($sformatf("R1 read addr %0d", a), rd, expv);
    end
    // Writes to ports that do not touch the mask (R1)
    for (int a = 0; a < 16; a++) begin
      if (a == 10 || a == 13 || a == 14 || a == 15) continue;
      cpuWrite(a[3:0], (a % 2 == 0) ? 8'hFF : 8'h00);
      check($sformatf("R1 write addr %0d no mask effect", a), {4'h0, maskOut}, 8'h05);
    end
    chanReq = 0;

    // All-mask write and read-back (R3, R4)
    for (int v = 0; v < 16; v++) begin
      cpuWrite(4'hF, {v[3:0] ^ 4'hA, v[3:0]});
      check("R3 write all mask", {4'h0, maskOut}, {4'h0, v[3:0]});
      cpuRead(4'hF, rd);
      check("R4 read all mask", rd, {4'hF, v[3:0]});
    end
    cpuWrite(4'hE, 8'hFF);
    check("R3 clear mask command", {4'h0, maskOut}, 8'h00);

    // Single-mask write sweep (R2)
    for (int init = 0; init < 16; init++) begin
      for (int ch = 0; ch < 4; ch++) begin
        for (int v = 0; v < 2; v++) begin
          logic [4:0] junk;
          junk = 5'(init * 7 + ch);
          cpuWrite(4'hF, 8'(init));
          cpuWrite(4'hA, {junk, v[0], ch[1:0]});
          expv = v[0] ? 8'(init | (1 << ch)) : 8'(init & ~(1 << ch));
          check($sformatf("R2 single init=%0d ch=%0d v=%0d", init, ch, v),
                {4'h0, maskOut}, expv);
        end
      end
    end

    // End-of-process mask set and status bits (R6, R7)
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 2; k++) begin
        for (int ai = 0; ai < 2; ai++) begin
          cpuWrite(4'hE, 8'h00);
          chanAutoInit = ai[0] ? 4'(1 << ch) : 4'h0;
          if (k == 0) pulseEnd(4'(1 << ch), 4'h0);
          else        pulseEnd(4'h0, 4'(1 << ch));
          chanAutoInit = 0;
          check($sformatf("R6 auto mask ch=%0d k=%0d ai=%0d", ch, k, ai),
                {4'h0, maskOut}, ai[0] ? 8'h00 : 8'(1 << ch));
          cpuRead(4'h8, rd);
          check("R7 status event bit", rd, 8'(1 << ch));
          cpuRead(4'h8, rd);
          check("R7 status cleared by read", rd, 8'h00);
        end
      end
    end

    // Terminal count on the clearing edge (R8)
    pulseEnd(4'b0001, 4'h0);
    cpuAddr = 4'h8; cpuRdN = 0;
    #5; rd = cpuDout;
    check("R8 status before clear", rd, 8'h01);
    @(negedge clk);
    cpuRdN = 1; chanTc = 4'b0100;
    @(negedge clk);
    chanTc = 0;
    @(negedge clk);
    cpuRead(4'h8, rd);
    check("R8 tc kept on clear edge", rd, 8'h04);

    // Request status regardless of mask (R9)
    cpuWrite(4'hF, 8'h0F);
    for (int r = 0; r < 16; r++) begin
      chanReq = r[3:0];
      @(negedge clk);
      cpuRead(4'h8, rd);
      check($sformatf("R9 request status r=%0d", r), rd, {r[3:0], 4'h0});
    end
    chanReq = 0;

    // Holding register (R10) and master clear (R5)
    tempDin = 8'hC3; tempLoad = 1; @(negedge clk); tempLoad = 0;
    cpuRead(4'hD, rd); check("R10 temp load C3", rd, 8'hC3);
    check("R10 temp output", tempValue, 8'hC3);
    tempDin = 8'h3C; tempLoad = 1; @(negedge clk); tempLoad = 0;
    cpuRead(4'hD, rd); check("R10 temp load 3C", rd, 8'h3C);
    cpuWrite(4'hE, 8'h00);
    pulseEnd(4'b0010, 4'h0);
    tempDin = 8'h77; tempLoad = 1;
    cpuAddr = 4'hD; cpuDin = 8'h00; cpuWrN = 0;
    @(negedge clk);
    cpuWrN = 1; tempLoad = 0;
    @(negedge clk);
    check("R10 master clear beats load", tempValue, 8'h00);
    check("R5 master clear mask", {4'h0, maskOut}, 8'h0F);
    cpuRead(4'h8, rd); check("R5 master clear status", rd, 8'h00);

    // Write beats automatic set on the written channel only (R11)
    cpuWrite(4'hE, 8'h00);
    cpuAddr = 4'hA; cpuDin = 8'b0000_0001; cpuWrN = 0; chanEop = 4'b0011;
    @(negedge clk);
    cpuWrN = 1; chanEop = 0;
    @(negedge clk);
    check("R11 single write vs eop", {4'h0, maskOut}, 8'h01);
    cpuAddr = 4'hF; cpuDin = 8'h00; cpuWrN = 0; chanTc = 4'b0100;
    @(negedge clk);
    cpuWrN = 1; chanTc = 0;
    @(negedge clk);
    check("R11 all write vs tc", {4'h0, maskOut}, 8'h00);
    cpuRead(4'h8, rd);

    // One commit per strobe (R12)
    cpuAddr = 4'hF; cpuDin = 8'h03; cpuWrN = 0;
    @(negedge clk);
    check("R12 mask after first low edge", {4'h0, maskOut}, 8'h03);
    chanEop = 4'b0100;
    @(negedge clk);
    chanEop = 0;
    @(negedge clk);
    @(negedge clk);
    cpuWrN = 1;
    @(negedge clk);
    check("R12 no repeat while held low", {4'h0, maskOut}, 8'h07);

    // Reset in mid-run (R5)
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R5 reset mid run", {4'h0, maskOut}, 8'h0F);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule